// File: doc/BRIEF.md
# Fence and Wait Synchronization Unit

This block gives a command stream two synchronization primitives built on one shared bank of sixteen 32-bit status registers. A fence command names a register, a 32-bit value and an event condition. It is queued, and when its condition holds it writes the value into the register. Software can then poll the register to learn how far the stream has progressed. A wait command stalls the stream until a chosen register passes a comparison against a value. The comparison is equality, wraparound-safe less-than, or wraparound-safe greater-or-equal.

Downstream units report their work through issue and completion pulses, in two classes: general work and render-target writes. When a fence is accepted it takes a ticket, which is the issue count of each class at that moment. A conditional fence retires once the completion count of its class has caught up with that ticket. A host register bus reads and writes the bank. A host write can therefore release a pending wait, and the same registers carry progress back to the host. Fences flagged as high priority also raise a one-cycle interrupt pulse.

Top module: `fence_wait_sync`

## Requirements
- R1: After reset every status register reads 0, `cmd_ready_o` is 1, `irq_o` is 0 and `host_rdata_o` is 0.
- R2: A host write (`host_req_i`=1, `host_we_i`=1) stores `host_wdata_i` at `host_addr_i`. A host read (`host_we_i`=0) returns, on `host_rdata_o` one clock edge later, the register value held before that edge.
- R3: A fence is `cmd_op_i`=0. A fence with event code 0 (immediate) accepted at edge k into an empty queue writes its register at edge k+1.
- R4: A fence with event code 1 retires only when the count of `work_done_i` pulses reaches the count of `work_issue_i` pulses seen before its acceptance cycle. Issues in the acceptance cycle count as later work.
- R5: A fence with event code 2 retires on the same rule, applied to `rt_issue_i` and `rt_done_i`. Pulses of the other class have no effect on it. Event code 3 requires both classes.
- R6: Fences retire strictly in acceptance order. An immediate fence queued behind a blocked fence does not write its register.
- R7: Up to 4 fences may be pending. With 4 pending, `cmd_ready_o` is 0 until one retires.
- R8: `cmd_op_i`=1 is a wait for equality. While the named register differs from the value, `cmd_ready_o` is 0. The stall ends in the cycle after the register matches, including when the match comes from a host write.
- R9: `cmd_op_i`=2 waits until (register − value), read as a signed 32-bit number, is negative. `cmd_op_i`=3 waits until that difference is non-negative. Both comparisons are correct across the 32-bit wrap.
- R10: A wait whose condition already holds when it is accepted causes no stall: `cmd_ready_o` stays 1.
- R11: When a fence write and a host write hit the same register in the same cycle, the fence value is stored.
- R12: Retiring a fence with `cmd_prio_i`=1 drives `irq_o` high for exactly the one cycle after its register write. An ordinary fence never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle if valid |
| cmd_op_i | input | 2 | 0 fence, 1 wait equal, 2 wait less-than, 3 wait greater-or-equal |
| cmd_event_i | input | 2 | Fence event: 0 immediate, 1 work done, 2 render-target done, 3 both |
| cmd_prio_i | input | 1 | Fence raises an interrupt on retirement |
| cmd_reg_i | input | 4 | Target status register |
| cmd_value_i | input | 32 | Fence value or wait operand |
| work_issue_i | input | 1 | General work dispatched downstream |
| work_done_i | input | 1 | General work completed |
| rt_issue_i | input | 1 | Render-target write work dispatched |
| rt_done_i | input | 1 | Render-target write work completed |
| host_req_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 4 | Host register index |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, one cycle latency |
| irq_o | output | 1 | High-priority fence pulse |

## Verification
Assertions watch the per-cycle invariants:
- the fence queue never overflows or underflows;
- completion counts never run ahead of issue counts;
- a satisfied pending wait always drops its stall on the next edge, and an unsatisfied one holds it;
- a fence write always lands over a colliding host write.

The directed scenarios show the behaviours that span several commands: retirement order behind a blocked fence, separation of the event classes, the exact cycle of a fence write and of the interrupt, and wraparound comparisons released by host writes.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);
  localparam int unsigned TKT_W    = 16;
  localparam int unsigned N_CLASS  = 2;  // 0: general work, 1: render-target writes

  typedef enum logic [1:0] {
    OP_FENCE   = 2'd0,
    OP_WAIT_EQ = 2'd1,
    OP_WAIT_LT = 2'd2,
    OP_WAIT_GE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    EV_NOW  = 2'd0,
    EV_WORK = 2'd1,
    EV_RT   = 2'd2,
    EV_BOTH = 2'd3
  } ev_e;

  typedef struct packed {
    logic                           prio;
    ev_e                            ev;
    logic [ADDR_W-1:0]              addr;
    logic [DATA_W-1:0]              value;
    logic [N_CLASS-1:0][TKT_W-1:0]  tkt;
  } fence_t;

  // wraparound-safe compare: sign of (cur - tgt)
  function automatic logic seq_cmp(op_e op, logic [DATA_W-1:0] cur, logic [DATA_W-1:0] tgt);
    logic [DATA_W-1:0] diff;
    diff = cur - tgt;
    case (op)
      OP_WAIT_EQ: seq_cmp = (cur == tgt);
      OP_WAIT_LT: seq_cmp = diff[DATA_W-1];
      OP_WAIT_GE: seq_cmp = !diff[DATA_W-1];
      default:    seq_cmp = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/fws_fifo.sv
module fws_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PTR_MAX  = PW'(DEPTH-1);
  localparam logic [PW:0]   FULL_CNT = (PW+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [PW:0]      cnt_q;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/fws_evt_track.sv
module fws_evt_track #(
  parameter int unsigned N = 2,
  parameter int unsigned W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        issue_i,
  input  logic [N-1:0]        done_i,
  output logic [N-1:0][W-1:0] issue_cnt_o,
  output logic [N-1:0][W-1:0] done_cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_class
    logic [W-1:0] iss_q, dn_q, gap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        iss_q <= '0;
        dn_q  <= '0;
      end else begin
        if (issue_i[g]) iss_q <= iss_q + 1'b1;
        if (done_i[g])  dn_q  <= dn_q + 1'b1;
      end
    end

    assign issue_cnt_o[g] = iss_q;
    assign done_cnt_o[g]  = dn_q;
    assign gap            = iss_q - dn_q;

    p_done_not_ahead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gap[W-1]);
  end
endmodule

// File: rtl/fws_status_bank.sv
module fws_status_bank
  import fws_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             host_we_i,
  input  logic                             host_re_i,
  input  logic [ADDR_W-1:0]                host_addr_i,
  input  logic [DATA_W-1:0]                host_wdata_i,
  output logic [DATA_W-1:0]                host_rdata_o,
  input  logic                             fence_we_i,
  input  logic [ADDR_W-1:0]                fence_addr_i,
  input  logic [DATA_W-1:0]                fence_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] reg_q;
    logic              hit_f, hit_h;

    assign hit_f = fence_we_i && (fence_addr_i == ADDR_W'(g));
    assign hit_h = host_we_i  && (host_addr_i  == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    reg_q <= '0;
      else if (hit_f) reg_q <= fence_data_i;   // fence beats host
      else if (hit_h) reg_q <= host_wdata_i;
    end

    assign regs_o[g] = reg_q;

    p_fence_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_f |=> reg_q == $past(fence_data_i));
    p_host_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_h && !hit_f) |=> reg_q == $past(host_wdata_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        host_rdata_o <= '0;
    else if (host_re_i) host_rdata_o <= regs_o[host_addr_i];
  end
endmodule

// File: rtl/fws_wait_ctrl.sv
module fws_wait_ctrl
  import fws_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             accept_i,
  input  op_e                              op_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                value_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  output logic                             busy_o
);
  logic              busy_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] val_q;
  logic              now_ok, held_ok;

  assign now_ok  = seq_cmp(op_i, regs_i[addr_i], value_i);
  assign held_ok = seq_cmp(op_q, regs_i[addr_q], val_q);
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_WAIT_EQ;
      addr_q <= '0;
      val_q  <= '0;
    end else if (accept_i) begin
      busy_q <= !now_ok;  // already satisfied: no stall
      op_q   <= op_i;
      addr_q <= addr_i;
      val_q  <= value_i;
    end else if (busy_q && held_ok) begin
      busy_q <= 1'b0;
    end
  end

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && held_ok) |=> !busy_q);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !held_ok) |=> busy_q);
  p_no_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> !busy_q);
endmodule

// File: rtl/fence_wait_sync.sv
module fence_wait_sync
  import fws_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [1:0]        cmd_event_i,
  input  logic              cmd_prio_i,
  input  logic [ADDR_W-1:0] cmd_reg_i,
  input  logic [DATA_W-1:0] cmd_value_i,
  input  logic              work_issue_i,
  input  logic              work_done_i,
  input  logic              rt_issue_i,
  input  logic              rt_done_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              irq_o
);
  localparam int unsigned FW = $bits(fence_t);

  op_e                            op;
  logic                           cmd_fire, push, pop, wait_acc;
  logic                           fifo_full, fifo_empty, wait_busy, head_ok;
  logic [N_CLASS-1:0][TKT_W-1:0]  issue_cnt, done_cnt;
  logic [N_CLASS-1:0]             met;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  fence_t                         new_f, head_f;
  logic [FW-1:0]                  head_raw;
  logic                           irq_q;

  assign op          = op_e'(cmd_op_i);
  assign cmd_ready_o = !wait_busy && !fifo_full;
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign push        = cmd_fire && (op == OP_FENCE);
  assign wait_acc    = cmd_fire && (op != OP_FENCE);

  always_comb begin
    new_f.prio  = cmd_prio_i;
    new_f.ev    = ev_e'(cmd_event_i);
    new_f.addr  = cmd_reg_i;
    new_f.value = cmd_value_i;
    new_f.tkt   = issue_cnt;   // issues in this cycle count as later work
  end

  fws_evt_track #(.N(N_CLASS), .W(TKT_W)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     ({rt_issue_i, work_issue_i}),
    .done_i      ({rt_done_i, work_done_i}),
    .issue_cnt_o (issue_cnt),
    .done_cnt_o  (done_cnt)
  );

  fws_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (new_f),
    .pop_i   (pop),
    .data_o  (head_raw),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  assign head_f = fence_t'(head_raw);

  for (genvar c = 0; c < N_CLASS; c++) begin : g_met
    logic [TKT_W-1:0] lag;
    assign lag    = done_cnt[c] - head_f.tkt[c];
    assign met[c] = !lag[TKT_W-1];
  end

  always_comb begin
    case (head_f.ev)
      EV_NOW:  head_ok = 1'b1;
      EV_WORK: head_ok = met[0];
      EV_RT:   head_ok = met[1];
      default: head_ok = &met;
    endcase
  end

  assign pop = !fifo_empty && head_ok;

  fws_status_bank i_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_req_i && host_we_i),
    .host_re_i    (host_req_i && !host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .fence_we_i   (pop),
    .fence_addr_i (head_f.addr),
    .fence_data_i (head_f.value),
    .regs_o       (regs)
  );

  fws_wait_ctrl i_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (wait_acc),
    .op_i     (op),
    .addr_i   (cmd_reg_i),
    .value_i  (cmd_value_i),
    .regs_i   (regs),
    .busy_o   (wait_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pop && head_f.prio;
  end
  assign irq_o = irq_q;

  p_irq_from_retire_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_empty && !head_ok) |=> !irq_o);
endmodule

// File: tb/test_fence_wait_sync.sv
module test_fence_wait_sync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_prio = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0, cmd_event = '0;
  logic [3:0]  cmd_reg = '0;
  logic [31:0] cmd_value = '0;
  logic        work_issue = 0, work_done = 0, rt_issue = 0, rt_done = 0;
  logic        host_req = 0, host_we = 0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        irq;
  int          n_checks = 0, n_fail = 0, irq_cnt = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  fence_wait_sync i_fence_wait_sync (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_event_i(cmd_event), .cmd_prio_i(cmd_prio), .cmd_reg_i(cmd_reg),
    .cmd_value_i(cmd_value),
    .work_issue_i(work_issue), .work_done_i(work_done),
    .rt_issue_i(rt_issue), .rt_done_i(rt_done),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [1:0] ev, input logic prio,
                          input logic [3:0] r, input logic [31:0] v);
    cmd_valid = 1; cmd_op = op; cmd_event = ev; cmd_prio = prio; cmd_reg = r; cmd_value = v;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [31:0] d);
    host_req = 1; host_we = 0; host_addr = a;
    @(posedge clk); @(negedge clk);
    d = host_rdata;
    host_req = 0;
  endtask

  task automatic pulse(input int sel);
    case (sel)
      0: work_issue = 1;
      1: work_done  = 1;
      2: rt_issue   = 1;
      default: rt_done = 1;
    endcase
    @(posedge clk); @(negedge clk);
    work_issue = 0; work_done = 0; rt_issue = 0; rt_done = 0;
  endtask

  task automatic t_reset;
    check("R1 ready", 32'(cmd_ready), 1);
    check("R1 irq", 32'(irq), 0);
    check("R1 rdata", host_rdata, 0);
    for (int i = 0; i < 16; i += 5) begin
      host_read(4'(i), rd);
      check("R1 reg", rd, 0);
    end
  endtask

  task automatic t_host;
    host_write(5, 32'hA5A5_0001);
    host_read(5, rd);
    check("R2 readback", rd, 32'hA5A5_0001);
  endtask

  task automatic t_now_fence;
    send_cmd(0, 0, 0, 2, 32'h11);
    host_read(2, rd);
    check("R3 before write edge", rd, 0);
    host_read(2, rd);
    check("R3 after write edge", rd, 32'h11);
  endtask

  task automatic t_work_fence;
    pulse(0); pulse(0);
    send_cmd(0, 1, 0, 3, 7);
    pulse(0);                       // later work: not part of ticket
    pulse(1); idle(2);
    host_read(3, rd);
    check("R4 one of two done", rd, 0);
    pulse(1); idle(2);
    host_read(3, rd);
    check("R4 all earlier done", rd, 7);
    pulse(1);                       // balance the later issue
  endtask

  task automatic t_rt_fence;
    pulse(2);
    send_cmd(0, 2, 0, 4, 9);
    pulse(0); pulse(1); idle(2);
    host_read(4, rd);
    check("R5 other class ignored", rd, 0);
    pulse(3); idle(2);
    host_read(4, rd);
    check("R5 rt done", rd, 9);
    pulse(0); pulse(2);
    send_cmd(0, 3, 0, 14, 3);
    pulse(1); idle(2);
    host_read(14, rd);
    check("R5 both, rt pending", rd, 0);
    pulse(3); idle(2);
    host_read(14, rd);
    check("R5 both done", rd, 3);
  endtask

  task automatic t_order;
    pulse(2);
    send_cmd(0, 2, 0, 6, 1);
    send_cmd(0, 0, 0, 7, 2);
    idle(3);
    host_read(7, rd);
    check("R6 blocked behind", rd, 0);
    pulse(3); idle(3);
    host_read(6, rd);
    check("R6 first", rd, 1);
    host_read(7, rd);
    check("R6 second", rd, 2);
  endtask

  task automatic t_full;
    pulse(0);
    for (int i = 1; i <= 4; i++) send_cmd(0, 1, 0, 8, 32'(i));
    check("R7 full stalls", 32'(cmd_ready), 0);
    idle(2);
    check("R7 still full", 32'(cmd_ready), 0);
    pulse(1); idle(6);
    check("R7 drained", 32'(cmd_ready), 1);
    host_read(8, rd);
    check("R7 last value", rd, 4);
  endtask

  task automatic t_wait_eq;
    send_cmd(1, 0, 0, 9, 5);
    check("R8 stall", 32'(cmd_ready), 0);
    idle(3);
    check("R8 still stalled", 32'(cmd_ready), 0);
    host_write(9, 5);
    check("R8 release edge", 32'(cmd_ready), 0);
    @(negedge clk);
    check("R8 released", 32'(cmd_ready), 1);
  endtask

  task automatic t_wrap;
    host_write(10, 32'hFFFF_FFF0);
    send_cmd(3, 0, 0, 10, 5);
    idle(1);
    check("R9 ge stalls across wrap", 32'(cmd_ready), 0);
    host_write(10, 8); idle(1);
    check("R9 ge released", 32'(cmd_ready), 1);
    send_cmd(2, 0, 0, 10, 3);
    idle(1);
    check("R9 lt stalls", 32'(cmd_ready), 0);
    host_write(10, 32'hFFFF_FFFE); idle(1);
    check("R9 lt released after wrap", 32'(cmd_ready), 1);
  endtask

  task automatic t_noop;
    host_write(11, 32'h42);
    send_cmd(1, 0, 0, 11, 32'h42);
    check("R10 eq no stall", 32'(cmd_ready), 1);
    send_cmd(3, 0, 0, 11, 32'h40);
    check("R10 ge no stall", 32'(cmd_ready), 1);
  endtask

  task automatic t_collide;
    send_cmd(0, 0, 0, 12, 32'hF);
    host_write(12, 32'hBAD);         // same edge as the fence write
    host_read(12, rd);
    check("R11 fence wins", rd, 32'hF);
  endtask

  task automatic t_irq;
    int base;
    base = irq_cnt;
    send_cmd(0, 0, 0, 13, 1);
    idle(3);
    check("R12 plain fence no irq", 32'(irq_cnt - base), 0);
    send_cmd(0, 0, 1, 13, 2);
    check("R12 irq not yet", 32'(irq), 0);
    @(negedge clk);
    check("R12 irq high", 32'(irq), 1);
    @(negedge clk);
    check("R12 irq one cycle", 32'(irq), 0);
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_host();
    t_now_fence();
    t_work_fence();
    t_rt_fence();
    t_order();
    t_full();
    t_wait_eq();
    t_wrap();
    t_noop();
    t_collide();
    t_irq();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule